// File: doc/BRIEF.md
# Security-Filtered Interrupt Bitmap Bank

This block keeps three one-bit state vectors (enable, pending and active) for the shared external interrupts of an interrupt controller. Software reaches each vector through a pair of 32-bit register windows. One window sets bits and the other clears them, and both read back the same stored state. A group bitmap, a per-interrupt edge/level configuration bit and a graded two-bit non-secure access field are held alongside. Every register access carries a secure/non-secure attribute. Each bit of an access is filtered by that attribute, by the interrupt's group bit and by its access field, so that non-secure software sees only the interrupts it is allowed to touch.

The block samples the interrupt input lines each clock. A rising edge sets the pending latch of an edge-configured interrupt. A level-configured line shows as pending for as long as it is high. The per-interrupt output `irqReady` is high when an interrupt is both pending and enabled, and feeds downstream arbitration. A single-bit `secDisable` input selects the single-security-state mode, in which every access sees every bit.

Top module: `irq_bitmap_bank`

## Requirements
- R1: In every bitmap window, interrupt IDs below 32 and IDs at or above NUM_IRQ read as zero and ignore writes.
- R2: In a set window a 1 sets the bit and a 0 leaves it unchanged. In a clear window a 1 clears the bit and a 0 leaves it unchanged. The set and clear windows of a vector read back the same stored state.
- R3: When `secDisable`=0 and `busSecure`=0, a bit is accessible only if its group bit is 1 or its access field grants the access. An inaccessible bit reads as zero and ignores writes. Secure accesses, and all accesses when `secDisable`=1, see all 32 bits.
- R4: The access field of an interrupt encodes 00 = no non-secure access, 01 = set-pending, 10 = 01 plus clear-pending and active reads, 11 = 10 plus routing. The set-pending window uses the test "field >= 1". The clear-pending window and reads of both active windows use "field >= 2". Enable windows, the edge window and writes to the active windows use the group bit alone.
- R5: Pending readback is the pending latch ORed with (sampled line level AND NOT edge bit), where edge bit 1 means edge-triggered. A clear-pending write therefore does not hide a high level-sensitive line.
- R6: A 0-to-1 transition of a sampled line sets the pending latch only if that interrupt's edge bit is 1. A line that holds its level sets nothing. When a rising edge and a clear-pending write hit the same interrupt in the same cycle, the latch ends up set.
- R7: The group window and the access-field window read as zero and ignore writes for non-secure accesses while `secDisable`=0. The access-field window also does so for every access while `secDisable`=1.
- R8: `busAddr[11:8]` selects the window: 0 group, 1 set-enable, 2 clear-enable, 3 set-pending, 4 clear-pending, 5 set-active, 6 clear-active, 7 edge configuration, 8 access fields. Other codes and addresses with `busAddr[1:0]`!=0 read as zero and ignore writes. In a bitmap window the word at byte offset `busAddr[7:0]` covers IDs from offset*8, with bit n mapped to ID offset*8+n.
- R9: An access-field word covers 16 interrupts starting at ID offset*4, with interrupt k of the word at bits [2k+1:2k]. Words covering IDs below 32 read as zero and ignore writes.
- R10: A write to the edge window replaces only the bits that pass the R4 mask and keeps the others.
- R11: `irqReady` equals pending readback AND enable, and follows a line change one clock later. Read data appears on `busRdata` one clock after the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, clears all state |
| secDisable | input | 1 | 1 selects the single-security-state mode |
| busValid | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSecure | input | 1 | Security attribute of the access, 1 = secure |
| busAddr | input | 12 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irqLine | input | NUM_IRQ | Interrupt input lines |
| irqReady | output | NUM_IRQ | Pending-and-enabled per interrupt |

## Verification
A write changes stored state at the clock edge that accepts it, so its effect appears in a read issued on the next access. That read returns data one edge later. The bench reads `busRdata` at the falling edge that follows the accepting rising edge. A line change is sampled at the next rising edge, and `irqReady` is checked at the falling edge after it. The bench drives the same-cycle rising-edge and clear-pending collision on one rising edge so that the result of that edge alone is checked.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

  typedef enum logic [3:0] {
    WIN_GROUP   = 4'd0,
    WIN_SETEN   = 4'd1,
    WIN_CLREN   = 4'd2,
    WIN_SETPEND = 4'd3,
    WIN_CLRPEND = 4'd4,
    WIN_SETACT  = 4'd5,
    WIN_CLRACT  = 4'd6,
    WIN_EDGE    = 4'd7,
    WIN_ACCESS  = 4'd8
  } win_e;

  // Per-bit permission applied to a non-secure access
  typedef enum logic [1:0] {
    MASK_ALL   = 2'd0,
    MASK_GROUP = 2'd1,
    MASK_GE1   = 2'd2,
    MASK_GE2   = 2'd3
  } mask_e;

  typedef struct packed {
    logic       wr;       // qualified write, already filtered for range/block
    logic       rd;       // read accepted, result captured next edge
    logic       zero;     // read returns zero, write ignored
    win_e       win;
    logic [5:0] wordIdx;
    mask_e      mask;
  } strobe_t;

endpackage

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
  import irqbank_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic        secDisable,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic        busSecure,
  input  logic [11:0] busAddr,
  output strobe_t     st
);
  localparam logic [6:0] BMP_WORDS = 7'(NUM_IRQ / 32);
  localparam logic [6:0] ACC_WORDS = 7'(NUM_IRQ / 16);

  logic [3:0] winCode;
  logic [5:0] idx;
  logic       nsView, known, inRange, blocked, zero;
  mask_e      maskSel;

  always_comb begin
    winCode = busAddr[11:8];
    idx     = busAddr[7:2];
    nsView  = !busSecure && !secDisable;
    known   = (winCode <= 4'd8);

    if (winCode == 4'd8) inRange = (idx >= 6'd2) && ({1'b0, idx} < ACC_WORDS);
    else                 inRange = (idx != 6'd0) && ({1'b0, idx} < BMP_WORDS);

    blocked = ((winCode == 4'd0) && nsView) ||
              ((winCode == 4'd8) && (nsView || secDisable));

    zero = !known || !inRange || blocked || (busAddr[1:0] != 2'b00);

    if (!nsView) maskSel = MASK_ALL;
    else begin
      case (winCode)
        4'd3:       maskSel = MASK_GE1;
        4'd4:       maskSel = MASK_GE2;
        4'd5, 4'd6: maskSel = busWrite ? MASK_GROUP : MASK_GE2;
        default:    maskSel = MASK_GROUP;
      endcase
    end

    st.wr      = busValid && busWrite && !zero;
    st.rd      = busValid && !busWrite;
    st.zero    = zero;
    st.win     = known ? win_e'(winCode) : WIN_GROUP;
    st.wordIdx = idx;
    st.mask    = maskSel;
  end

endmodule

// File: rtl/irqbank_datapath.sv
module irqbank_datapath
  import irqbank_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [31:0]        wdata,
  input  logic [NUM_IRQ-1:0] lineIn,
  output logic [31:0]        rdData,
  output logic [NUM_IRQ-1:0] pendView,
  output logic [NUM_IRQ-1:0] enVec
);
  localparam int NW = NUM_IRQ / 32;
  localparam int NA = NUM_IRQ / 16;
  localparam int AW = 2 * NUM_IRQ;

  logic [NUM_IRQ-1:0] grpQ, enQ, pendQ, actQ, edgeQ, lvlQ;
  logic [NUM_IRQ-1:0] grpD, enD, pendD, actD, edgeD, lvlD;
  logic [NUM_IRQ-1:0] ge1, ge2;
  logic [AW-1:0]      accQ, accD;
  logic [31:0]        rdBmp [NW];
  logic [31:0]        rdNext;

  genvar gi, gw, ga;

  for (gi = 0; gi < NUM_IRQ; gi++) begin : g_grade
    assign ge1[gi] = accQ[2*gi] | accQ[2*gi+1];
    assign ge2[gi] = accQ[2*gi+1];
  end

  for (gw = 0; gw < NW; gw++) begin : g_word
    localparam logic [5:0] WI = 6'(gw);
    logic        hit;
    logic [31:0] grp, en, pend, act, edg, lvl, line;
    logic [31:0] m, val, setEn, clrEn, setPd, clrPd, setAc, clrAc, rise, pv;

    assign grp  = grpQ[gw*32 +: 32];
    assign en   = enQ[gw*32 +: 32];
    assign pend = pendQ[gw*32 +: 32];
    assign act  = actQ[gw*32 +: 32];
    assign edg  = edgeQ[gw*32 +: 32];
    assign lvl  = lvlQ[gw*32 +: 32];
    assign line = lineIn[gw*32 +: 32];
    assign hit  = st.wr && (st.wordIdx == WI);

    always_comb begin
      case (st.mask)
        MASK_ALL:   m = 32'hFFFF_FFFF;
        MASK_GROUP: m = grp;
        MASK_GE1:   m = grp | ge1[gw*32 +: 32];
        default:    m = grp | ge2[gw*32 +: 32];
      endcase
    end

    assign val   = wdata & m;
    assign setEn = (hit && st.win == WIN_SETEN)   ? val : '0;
    assign clrEn = (hit && st.win == WIN_CLREN)   ? val : '0;
    assign setPd = (hit && st.win == WIN_SETPEND) ? val : '0;
    assign clrPd = (hit && st.win == WIN_CLRPEND) ? val : '0;
    assign setAc = (hit && st.win == WIN_SETACT)  ? val : '0;
    assign clrAc = (hit && st.win == WIN_CLRACT)  ? val : '0;
    assign rise  = line & ~lvl & edg;
    assign pv    = pend | (lvl & ~edg);

    if (gw == 0) begin : g_raz
      assign grpD[31:0]  = '0;
      assign enD[31:0]   = '0;
      assign pendD[31:0] = '0;
      assign actD[31:0]  = '0;
      assign edgeD[31:0] = '0;
      assign lvlD[31:0]  = '0;
    end else begin : g_live
      assign grpD[gw*32 +: 32]  = (hit && st.win == WIN_GROUP) ? wdata : grp;
      assign enD[gw*32 +: 32]   = (en | setEn) & ~clrEn;
      // a same-cycle rising edge overrides a clear-pending write
      assign pendD[gw*32 +: 32] = ((pend | setPd) & ~clrPd) | rise;
      assign actD[gw*32 +: 32]  = (act | setAc) & ~clrAc;
      assign edgeD[gw*32 +: 32] = (hit && st.win == WIN_EDGE) ? ((edg & ~m) | val) : edg;
      assign lvlD[gw*32 +: 32]  = line;
    end

    assign pendView[gw*32 +: 32] = pv;

    always_comb begin
      case (st.win)
        WIN_GROUP:               rdBmp[gw] = grp;
        WIN_SETEN, WIN_CLREN:     rdBmp[gw] = en & m;
        WIN_SETPEND, WIN_CLRPEND: rdBmp[gw] = pv & m;
        WIN_SETACT, WIN_CLRACT:   rdBmp[gw] = act & m;
        WIN_EDGE:                 rdBmp[gw] = edg & m;
        default:                  rdBmp[gw] = '0;
      endcase
    end
  end

  for (ga = 0; ga < NA; ga++) begin : g_acc
    localparam logic [5:0] AI = 6'(ga);
    if (ga < 2) begin : g_raz
      assign accD[ga*32 +: 32] = '0;
    end else begin : g_live
      assign accD[ga*32 +: 32] =
        (st.wr && st.win == WIN_ACCESS && st.wordIdx == AI) ? wdata : accQ[ga*32 +: 32];
    end
  end

  always_comb begin
    rdNext = '0;
    if (!st.zero) begin
      if (st.win == WIN_ACCESS) begin
        for (int a = 0; a < NA; a++)
          if (st.wordIdx == 6'(a)) rdNext = accQ[a*32 +: 32];
      end else begin
        for (int w = 0; w < NW; w++)
          if (st.wordIdx == 6'(w)) rdNext = rdBmp[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpQ   <= '0;
      enQ    <= '0;
      pendQ  <= '0;
      actQ   <= '0;
      edgeQ  <= '0;
      lvlQ   <= '0;
      accQ   <= '0;
      rdData <= '0;
    end else begin
      grpQ  <= grpD;
      enQ   <= enD;
      pendQ <= pendD;
      actQ  <= actD;
      edgeQ <= edgeD;
      lvlQ  <= lvlD;
      accQ  <= accD;
      if (st.rd) rdData <= rdNext;
    end
  end

  assign enVec = enQ;

endmodule

// File: rtl/irq_bitmap_bank.sv
module irq_bitmap_bank
  import irqbank_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               secDisable,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic               busSecure,
  input  logic [11:0]        busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_IRQ-1:0] irqLine,
  output logic [NUM_IRQ-1:0] irqReady
);
  strobe_t            st;
  logic [NUM_IRQ-1:0] pendView, enVec;

  irqbank_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .secDisable(secDisable),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busSecure (busSecure),
    .busAddr   (busAddr),
    .st        (st)
  );

  irqbank_datapath #(.NUM_IRQ(NUM_IRQ)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wdata   (busWdata),
    .lineIn  (irqLine),
    .rdData  (busRdata),
    .pendView(pendView),
    .enVec   (enVec)
  );

  assign irqReady = pendView & enVec;

endmodule

// File: rtl/irqbank_checker.sv
module irqbank_checker #(
  parameter int NUM_IRQ = 96
) (
  input logic               clk,
  input logic               rstN,
  input logic               secDisable,
  input logic               busValid,
  input logic               busWrite,
  input logic               busSecure,
  input logic [11:0]        busAddr,
  input logic [31:0]        busWdata,
  input logic [31:0]        busRdata,
  input logic [NUM_IRQ-1:0] enVec
);

  // R1: the word holding IDs 0..31 always reads zero in bitmap windows
  a_r1_internal_raz: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr[11:8] <= 4'd7 && busAddr[7:2] == 6'd0)
    |=> (busRdata == 32'd0));

  // R7: group window hidden from non-secure view
  a_r7_group_ns_raz: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && !busSecure && !secDisable && busAddr[11:8] == 4'd0)
    |=> (busRdata == 32'd0));

  // R7: access-field window hidden in single-security mode
  a_r7_access_ds_raz: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && secDisable && busAddr[11:8] == 4'd8)
    |=> (busRdata == 32'd0));

  // R2: secure all-ones set-enable to IDs 32..63 sets every bit
  a_r2_set_enable: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busSecure && busAddr == 12'h104 && busWdata == 32'hFFFF_FFFF)
    |=> (enVec[63:32] == 32'hFFFF_FFFF));

  // R2: secure all-ones clear-enable to IDs 32..63 clears every bit
  a_r2_clear_enable: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busSecure && busAddr == 12'h204 && busWdata == 32'hFFFF_FFFF)
    |=> (enVec[63:32] == 32'd0));

endmodule

bind irq_bitmap_bank irqbank_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .secDisable(secDisable),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busSecure (busSecure),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .enVec     (enVec)
);

// File: tb/sim_irq_bitmap_bank.sv
`timescale 1ns/1ps
module sim_irq_bitmap_bank;
  localparam int NUM_IRQ = 96;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               secDisable = 1'b0;
  logic               busValid = 1'b0;
  logic               busWrite = 1'b0;
  logic               busSecure = 1'b0;
  logic [11:0]        busAddr = '0;
  logic [31:0]        busWdata = '0;
  logic [31:0]        busRdata;
  logic [NUM_IRQ-1:0] irqLine = '0;
  logic [NUM_IRQ-1:0] irqReady;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_bitmap_bank #(.NUM_IRQ(NUM_IRQ)) u0 (
    .clk(clk), .rstN(rstN), .secDisable(secDisable),
    .busValid(busValid), .busWrite(busWrite), .busSecure(busSecure),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqLine(irqLine), .irqReady(irqReady)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busSecure = sec; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic sec, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busSecure = sec; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    check("R11 reset irqReady", irqReady[31:0] | irqReady[63:32] | irqReady[95:64], 32'd0);
    rd(12'h104, 1'b1, d);
    check("R2 reset enable word", d, 32'd0);
  endtask

  task automatic test_set_clear();
    logic [31:0] d;
    wr(12'h104, 32'h0000_00F0, 1'b1);
    rd(12'h104, 1'b1, d); check("R2 set-enable", d, 32'h0000_00F0);
    wr(12'h204, 32'h0000_0030, 1'b1);
    rd(12'h204, 1'b1, d); check("R2 clear view readback", d, 32'h0000_00C0);
    rd(12'h104, 1'b1, d); check("R2 set view readback", d, 32'h0000_00C0);
    wr(12'h108, 32'h0000_0001, 1'b1);
    rd(12'h208, 1'b1, d); check("R8 word2 bit0 is ID64", d, 32'h0000_0001);
    wr(12'h208, 32'hFFFF_FFFF, 1'b1);
    wr(12'h204, 32'hFFFF_FFFF, 1'b1);
    rd(12'h104, 1'b1, d); check("R2 all cleared", d, 32'd0);
  endtask

  task automatic test_raz();
    logic [31:0] d;
    wr(12'h100, 32'hFFFF_FFFF, 1'b1);
    rd(12'h100, 1'b1, d); check("R1 IDs below 32", d, 32'd0);
    wr(12'h10C, 32'hFFFF_FFFF, 1'b1);
    rd(12'h10C, 1'b1, d); check("R1 IDs at NUM_IRQ", d, 32'd0);
    rd(12'h104, 1'b1, d); check("R1 neighbour untouched", d, 32'd0);
    wr(12'h105, 32'hFFFF_FFFF, 1'b1);
    rd(12'h104, 1'b1, d); check("R8 misaligned write ignored", d, 32'd0);
    wr(12'hF04, 32'hFFFF_FFFF, 1'b1);
    rd(12'hF04, 1'b1, d); check("R8 unknown window", d, 32'd0);
  endtask

  task automatic test_group_mask();
    logic [31:0] d;
    wr(12'h004, 32'h0000_000F, 1'b1);
    wr(12'h104, 32'h0000_00FF, 1'b0);
    rd(12'h104, 1'b1, d); check("R3 ns set only group bits", d, 32'h0000_000F);
    wr(12'h104, 32'h0000_00FF, 1'b1);
    rd(12'h104, 1'b0, d); check("R3 ns read masked", d, 32'h0000_000F);
    rd(12'h104, 1'b1, d); check("R3 secure read full", d, 32'h0000_00FF);
    secDisable = 1'b1;
    wr(12'h204, 32'h0000_00FF, 1'b0);
    rd(12'h104, 1'b1, d); check("R3 single-state ns clear all", d, 32'd0);
    secDisable = 1'b0;
    wr(12'h004, 32'd0, 1'b1);
  endtask

  task automatic test_access_grade();
    logic [31:0] d;
    // ID40 field 01 at [17:16], ID41 field 10 at [19:18] of word 0x808
    wr(12'h808, 32'h0009_0000, 1'b1);
    wr(12'h304, 32'h0000_0300, 1'b0);
    rd(12'h304, 1'b1, d); check("R4 ns set-pending ge1", d, 32'h0000_0300);
    rd(12'h304, 1'b0, d); check("R4 ns set-pending read", d, 32'h0000_0300);
    rd(12'h404, 1'b0, d); check("R4 ns clear-pending read ge2", d, 32'h0000_0200);
    wr(12'h404, 32'h0000_0300, 1'b0);
    rd(12'h304, 1'b1, d); check("R4 ns clear-pending ge2", d, 32'h0000_0100);
    wr(12'h504, 32'h0000_0300, 1'b1);
    rd(12'h504, 1'b0, d); check("R4 ns active read ge2", d, 32'h0000_0200);
    wr(12'h604, 32'h0000_0300, 1'b0);
    rd(12'h504, 1'b1, d); check("R4 ns active write group only", d, 32'h0000_0300);
    wr(12'h404, 32'hFFFF_FFFF, 1'b1);
    wr(12'h604, 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic test_ns_blocked();
    logic [31:0] d;
    wr(12'h004, 32'h0000_0005, 1'b1);
    rd(12'h004, 1'b0, d); check("R7 ns group read", d, 32'd0);
    wr(12'h004, 32'h0000_FFFF, 1'b0);
    rd(12'h004, 1'b1, d); check("R7 ns group write ignored", d, 32'h0000_0005);
    rd(12'h808, 1'b0, d); check("R7 ns access read", d, 32'd0);
    wr(12'h808, 32'd0, 1'b0);
    rd(12'h808, 1'b1, d); check("R7 ns access write ignored", d, 32'h0009_0000);
    secDisable = 1'b1;
    rd(12'h808, 1'b1, d); check("R7 single-state access read", d, 32'd0);
    wr(12'h808, 32'd0, 1'b1);
    secDisable = 1'b0;
    rd(12'h808, 1'b1, d); check("R7 single-state access write ignored", d, 32'h0009_0000);
    wr(12'h804, 32'hFFFF_FFFF, 1'b1);
    rd(12'h804, 1'b1, d); check("R9 access word for IDs 16..31", d, 32'd0);
  endtask

  task automatic test_level();
    logic [31:0] d;
    wr(12'h104, 32'h0004_0000, 1'b1);   // enable ID50
    @(negedge clk); irqLine[50] = 1'b1;
    tick();
    check("R11 level line to irqReady", {31'd0, irqReady[50]}, 32'd1);
    rd(12'h304, 1'b1, d); check("R5 level shows pending", d, 32'h0004_0000);
    wr(12'h404, 32'h0004_0000, 1'b1);
    rd(12'h304, 1'b1, d); check("R5 clear keeps level view", d, 32'h0004_0000);
    @(negedge clk); irqLine[50] = 1'b0;
    tick();
    check("R11 level drop", {31'd0, irqReady[50]}, 32'd0);
    rd(12'h304, 1'b1, d); check("R5 pending after drop", d, 32'd0);
    wr(12'h204, 32'h0004_0000, 1'b1);
  endtask

  task automatic test_edge();
    logic [31:0] d;
    wr(12'h704, 32'h1000_0000, 1'b1);   // ID60 edge-triggered
    wr(12'h104, 32'h1000_0000, 1'b1);
    @(negedge clk); irqLine[60] = 1'b1;
    tick();
    check("R6 rising edge latches", {31'd0, irqReady[60]}, 32'd1);
    @(negedge clk); irqLine[60] = 1'b0;
    tick();
    check("R6 latch survives line drop", {31'd0, irqReady[60]}, 32'd1);
    rd(12'h304, 1'b1, d); check("R6 pending readback", d, 32'h1000_0000);
    wr(12'h404, 32'h1000_0000, 1'b1);
    @(negedge clk); irqLine[60] = 1'b1;
    tick();
    wr(12'h404, 32'h1000_0000, 1'b1);
    tick(); tick();
    rd(12'h304, 1'b1, d); check("R6 held level sets nothing", d, 32'd0);
    @(negedge clk); irqLine[60] = 1'b0;
    tick();
    // rising edge and clear-pending in the same cycle
    @(negedge clk);
    irqLine[60] = 1'b1;
    busValid = 1'b1; busWrite = 1'b1; busSecure = 1'b1;
    busAddr = 12'h404; busWdata = 32'h1000_0000;
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    rd(12'h304, 1'b1, d); check("R6 edge beats clear", d, 32'h1000_0000);
    // group word1 = 0x5 from earlier; ns edge write touches IDs 32 and 34 only
    wr(12'h704, 32'h0000_0007, 1'b0);
    rd(12'h704, 1'b1, d); check("R10 ns edge write masked", d, 32'h1000_0005);
    irqLine[60] = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_set_clear();
    test_raz();
    test_group_mask();
    test_access_grade();
    test_ns_blocked();
    test_level();
    test_edge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule